// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It finds the one dependence that operand forwarding cannot resolve in time: a memory load in the execute stage whose result is needed by the instruction now in decode. When it sees that case, it holds the program counter and the fetch/decode register for one cycle. It also sends an all-zero control word into the decode/execute register, so the dependent instruction waits in decode while a no-op bubble moves forward.

The block owns the decode/execute control and destination register. From that register it takes the execute-stage memory-read flag and target register. Each cycle it compares that target with both source-register fields of the instruction in decode. Register 0 always reads as zero, so it never causes a stall. After the single bubble, the forwarding network, which is outside this block, supplies the loaded value. The fetch logic and the datapath use the two write enables to stall.

Top module: `lus_stall_ctrl`

## Requirements
- R1: `stall` is 1 in the same cycle when bit 0 of `ex_ctrl` (the memory-read flag) is 1, `ex_dst` is non-zero, and `ex_dst` equals `id_rs1`.
- R2: `stall` is 1 in the same cycle when bit 0 of `ex_ctrl` is 1, `ex_dst` is non-zero, and `ex_dst` equals `id_rs2`.
- R3: When `ex_dst` is 0, `stall` is 0, even if a source field is also 0 and the execute stage holds a load.
- R4: When bit 0 of `ex_ctrl` is 0, `stall` is 0, whatever the register fields are.
- R5: `pc_we` and `ifid_we` are both 0 in a stall cycle and both 1 in every other cycle.
- R6: At the clock edge that ends a stall cycle, `ex_ctrl` is loaded with all zeros. This clears the memory-read (bit 0), memory-write (bit 1), register-write (bit 2), load-to-register select (bit 3) and ALU-operation (bits 4 and up) fields.
- R7: At every clock edge that ends a cycle without a stall, `ex_ctrl` takes `id_ctrl` unchanged. At every edge, stalled or not, `ex_dst` takes `id_dst`, so the execute stage keeps advancing.
- R8: A stall never lasts more than one cycle: a stall cycle is always followed by a cycle without a stall.
- R9: While `rst_n` is 0 at a clock edge, `ex_ctrl` and `ex_dst` are cleared to 0, so no false memory read is seen after reset.
- R10: Only the instruction directly in the execute stage is checked. A consumer two slots behind a load does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the decode-stage instruction |
| id_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| id_dst | input | REG_W | Destination register of the decode-stage instruction |
| id_ctrl | input | 4+ALU_W | Decoded control word (bit0 mem read, bit1 mem write, bit2 reg write, bit3 load-to-reg, upper bits ALU op) |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| stall | output | 1 | Load-use hazard flag for this cycle |
| ex_ctrl | output | 4+ALU_W | Execute-stage control word (decode/execute register) |
| ex_dst | output | REG_W | Execute-stage destination register |

## Verification
The bench targets these corner cases:

- A load into register 0 followed by a reader of register 0. A design without the zero guard would stall here for no reason.
- An ALU write followed by a reader of the same register. A detector that ignores the memory-read flag would stall on every dependence that forwarding could cover.
- A consumer two slots behind its load, and a load whose address depends on the load just before it. A wrong design would stall a second time, or would never release the held instruction.
- The cycle after each stall. The bench checks that the bubble carries zero control bits while the destination field still advances. A mux placed on the wrong path would leak a write-enable or freeze the execute stage.

// File: rtl/lus_pkg.sv
// Package: shared bit positions of the decoded control word.
// Assumes the low four bits are single-bit flags and the ALU
// operation fills the bits above them.
package lus_pkg;
    localparam int CTL_MEMRD    = 0;
    localparam int CTL_MEMWR    = 1;
    localparam int CTL_REGWR    = 2;
    localparam int CTL_LDTOREG  = 3;
    localparam int CTL_ALU_LSB  = 4;
endpackage

// File: rtl/lus_hazard_detect.sv
// Module: compares the execute-stage load target with every
// decode-stage source field and flags a load-use hazard.
// Assumes register 0 is hardwired to zero and never a real dependence.
module lus_hazard_detect #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                  ex_mem_read,
    input  logic [REG_W-1:0]      ex_dst,
    input  logic [NSRC*REG_W-1:0] id_srcs,
    output logic                  hazard
);
    logic [NSRC-1:0] src_hit;
    logic            dst_live;

    // one equality comparator per source field
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign src_hit[g] = (id_srcs[g*REG_W +: REG_W] == ex_dst);
    end

    // combine: a load, a non-zero target and at least one match
    always_comb begin
        dst_live = (ex_dst != '0);
        hazard   = ex_mem_read && dst_live && (|src_hit);
    end
endmodule

// File: rtl/lus_stall_actions.sv
// Module: turns the hazard flag into the stall actions: it holds the
// program counter and the fetch/decode register, and it swaps the
// control word for a zero bubble. Data fields are left untouched.
module lus_stall_actions #(
    parameter int CTRL_W = 8
) (
    input  logic              hazard,
    input  logic [CTRL_W-1:0] id_ctrl,
    output logic              pc_we,
    output logic              ifid_we,
    output logic [CTRL_W-1:0] idex_ctrl_d
);
    // write enables drop and control is zeroed while the hazard is up
    always_comb begin
        pc_we       = !hazard;
        ifid_we     = !hazard;
        idex_ctrl_d = hazard ? '0 : id_ctrl;
    end
endmodule

// File: rtl/lus_idex_reg.sv
// Module: decode/execute register for the control word and the
// destination field. It has no enable, so it advances every cycle.
// Synchronous active-low reset clears both fields.
module lus_idex_reg #(
    parameter int CTRL_W = 8,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_d,
    input  logic [REG_W-1:0]  dst_d,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [REG_W-1:0]  dst_q
);
    // capture the next execute-stage contents, or clear them on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dst_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            dst_q  <= dst_d;
        end
    end
endmodule

// File: rtl/lus_stall_ctrl.sv
// Module: top of the load-use stall controller. It joins the hazard
// detector, the stall actions and the decode/execute register.
// Assumes forwarding outside this block covers every other dependence.
module lus_stall_ctrl #(
    parameter int REG_W = 5,
    parameter int ALU_W = 4,
    localparam int CTRL_W = lus_pkg::CTL_ALU_LSB + ALU_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  id_rs1,
    input  logic [REG_W-1:0]  id_rs2,
    input  logic [REG_W-1:0]  id_dst,
    input  logic [CTRL_W-1:0] id_ctrl,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              stall,
    output logic [CTRL_W-1:0] ex_ctrl,
    output logic [REG_W-1:0]  ex_dst
);
    logic              hazard;
    logic [CTRL_W-1:0] idex_ctrl_d;

    lus_hazard_detect #(.REG_W(REG_W), .NSRC(2)) u_detect (
        .ex_mem_read (ex_ctrl[lus_pkg::CTL_MEMRD]),
        .ex_dst      (ex_dst),
        .id_srcs     ({id_rs2, id_rs1}),
        .hazard      (hazard)
    );

    lus_stall_actions #(.CTRL_W(CTRL_W)) u_actions (
        .hazard      (hazard),
        .id_ctrl     (id_ctrl),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .idex_ctrl_d (idex_ctrl_d)
    );

    lus_idex_reg #(.CTRL_W(CTRL_W), .REG_W(REG_W)) u_idex (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_d (idex_ctrl_d),
        .dst_d  (id_dst),
        .ctrl_q (ex_ctrl),
        .dst_q  (ex_dst)
    );

    // the stall flag mirrors the detector output
    assign stall = hazard;
endmodule

// File: rtl/lus_stall_ctrl_sva.sv
// Module: assertion checker for lus_stall_ctrl, attached by bind.
// It watches only the top-level ports.
module lus_stall_ctrl_sva #(
    parameter int REG_W  = 5,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  id_rs1,
    input logic [REG_W-1:0]  id_rs2,
    input logic [CTRL_W-1:0] id_ctrl,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              stall,
    input logic [CTRL_W-1:0] ex_ctrl,
    input logic [REG_W-1:0]  ex_dst
);
    p_hit_rs1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ctrl[0] && ex_dst != '0 && ex_dst == id_rs1) |-> stall);

    p_hit_rs2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ctrl[0] && ex_dst != '0 && ex_dst == id_rs2) |-> stall);

    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !stall);

    p_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ctrl[0] |-> !stall);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!pc_we && !ifid_we));

    p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (pc_we && ifid_we));

    p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_ctrl == '0));

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (ex_ctrl == $past(id_ctrl)));

    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (ex_ctrl == '0 && ex_dst == '0));
endmodule

bind lus_stall_ctrl lus_stall_ctrl_sva #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_rs1  (id_rs1),
    .id_rs2  (id_rs2),
    .id_ctrl (id_ctrl),
    .pc_we   (pc_we),
    .ifid_we (ifid_we),
    .stall   (stall),
    .ex_ctrl (ex_ctrl),
    .ex_dst  (ex_dst)
);

// File: tb/lus_stall_ctrl_bench.sv
`timescale 1ns/1ps
module lus_stall_ctrl_bench;
    localparam int REG_W  = 5;
    localparam int ALU_W  = 4;
    localparam int CTRL_W = 4 + ALU_W;
    localparam int N_DIR  = 14;
    localparam int N_CYC  = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_W-1:0]  id_rs1 = '0, id_rs2 = '0, id_dst = '0;
    logic [CTRL_W-1:0] id_ctrl = '0;
    logic              pc_we, ifid_we, stall;
    logic [CTRL_W-1:0] ex_ctrl;
    logic [REG_W-1:0]  ex_dst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side pipeline model
    logic [CTRL_W-1:0] m_ex_ctrl, m_mem_ctrl;
    logic [REG_W-1:0]  m_ex_dst, m_mem_dst;
    bit fetch_new, prev_stall;
    int pc;

    always #2 clk = ~clk;

    lus_stall_ctrl #(.REG_W(REG_W), .ALU_W(ALU_W)) u_lus_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_dst(id_dst), .id_ctrl(id_ctrl), .pc_we(pc_we), .ifid_we(ifid_we),
        .stall(stall), .ex_ctrl(ex_ctrl), .ex_dst(ex_dst)
    );

    localparam logic [CTRL_W-1:0] LOAD_CTL = 8'h2D; // mem read, reg write, load-to-reg, alu add
    localparam logic [CTRL_W-1:0] ALU_CTL  = 8'h34; // reg write only

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // directed program: {is_load, dst, rs1, rs2}
    function automatic logic [15:0] dir_instr(int i);
        case (i)
            0:  return {1'b1, 5'd5, 5'd1, 5'd2};
            1:  return {1'b0, 5'd9, 5'd5, 5'd3};  // R1 consumer
            2:  return {1'b1, 5'd6, 5'd1, 5'd1};
            3:  return {1'b0, 5'd9, 5'd2, 5'd6};  // R2 consumer
            4:  return {1'b1, 5'd0, 5'd1, 5'd1};
            5:  return {1'b0, 5'd9, 5'd0, 5'd0};  // R3 reader of reg 0
            6:  return {1'b0, 5'd7, 5'd1, 5'd2};
            7:  return {1'b0, 5'd9, 5'd7, 5'd7};  // R4 ALU producer
            8:  return {1'b1, 5'd4, 5'd1, 5'd2};
            9:  return {1'b0, 5'd9, 5'd1, 5'd2};
            10: return {1'b0, 5'd9, 5'd4, 5'd4};  // R10 two slots behind
            11: return {1'b1, 5'd3, 5'd1, 5'd2};
            12: return {1'b1, 5'd3, 5'd3, 5'd1};  // chained load
            default: return {1'b0, 5'd9, 5'd3, 5'd3};
        endcase
    endfunction

    task automatic fetch();
        logic [15:0] w;
        if (pc < N_DIR) begin
            w = dir_instr(pc);
            id_ctrl = w[15] ? LOAD_CTL : ALU_CTL;
            id_dst = w[14:10]; id_rs1 = w[9:5]; id_rs2 = w[4:0];
        end else begin
            id_dst = REG_W'($urandom % 8);
            id_rs1 = REG_W'($urandom % 8);
            id_rs2 = REG_W'($urandom % 8);
            if ($urandom % 3 == 0) id_ctrl = LOAD_CTL;
            else id_ctrl = {4'($urandom), 3'($urandom), 1'b0};
        end
        pc++;
    endtask

    function automatic bit src_match(logic [REG_W-1:0] d);
        return (d == id_rs1) || (d == id_rs2);
    endfunction

    // one pipeline cycle, entered just after a falling edge
    task automatic cycle();
        bit e_stall;
        string tag;
        check(prev_stall ? "R6" : "R7", "ex_ctrl", int'(ex_ctrl), int'(m_ex_ctrl));
        check("R7", "ex_dst", int'(ex_dst), int'(m_ex_dst));
        if (fetch_new) fetch();
        #1;
        e_stall = m_ex_ctrl[0] && (m_ex_dst != 0) && src_match(m_ex_dst);
        if (e_stall) tag = (m_ex_dst == id_rs1) ? "R1" : "R2";
        else if (m_ex_ctrl[0] && m_ex_dst == 0 && src_match(m_ex_dst)) tag = "R3";
        else if (!m_ex_ctrl[0] && m_ex_dst != 0 && src_match(m_ex_dst)) tag = "R4";
        else if (m_mem_ctrl[0] && m_mem_dst != 0 && src_match(m_mem_dst)) tag = "R10";
        else tag = "R1";
        check(tag, "stall", int'(stall), int'(e_stall));
        check("R5", "pc_we", int'(pc_we), int'(!e_stall));
        check("R5", "ifid_we", int'(ifid_we), int'(!e_stall));
        if (prev_stall) check("R8", "stall after stall", int'(stall), 0);
        m_mem_ctrl = m_ex_ctrl;
        m_mem_dst  = m_ex_dst;
        m_ex_ctrl  = e_stall ? '0 : id_ctrl;
        m_ex_dst   = id_dst;
        fetch_new  = !e_stall;
        prev_stall = e_stall;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // hold reset with a load-like word on the decode inputs
        id_ctrl = LOAD_CTL; id_dst = 5'd5; id_rs1 = 5'd5; id_rs2 = 5'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "reset ex_ctrl", int'(ex_ctrl), 0);
        check("R9", "reset ex_dst", int'(ex_dst), 0);
        check("R9", "reset stall", int'(stall), 0);
        rst_n = 1'b1;
        m_ex_ctrl = '0; m_ex_dst = '0; m_mem_ctrl = '0; m_mem_dst = '0;
        fetch_new = 1; prev_stall = 0; pc = 0;
        for (int i = 0; i < N_CYC; i++) cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule